// File: doc/BRIEF.md
# Diagonal Interleaved Parity Codec

This block protects a 16-bit word stream with a 4-bit diagonal interleaved parity. It has two independent halves. The egress half sits in front of the transmit side of a link. It folds every data word into a running parity, and when a control word arrives it writes the resulting 4-bit code into that control word's parity field. The ingress half sits behind the receive side. It runs the same accumulation over the incoming words, recomputes the code when a control word arrives, and raises a one-cycle error flag if the received field does not match.

The running value is a 16-bit accumulator. For each valid word, the accumulator is rotated left by one bit and the word is XORed into it. The control word that closes an interval also enters the calculation, but with its parity field, bits [3:0], forced to all ones. The 16-bit result is then reduced to 4 bits by XORing its four nibbles together, and the accumulator restarts from zero for the next interval. Each stream is qualified by a valid strobe and a control/data flag; cycles without the strobe do not affect the calculation.

Top module: `diag_parity_unit`

## Requirements
- R1: While and immediately after reset, tx_valid_o and rx_err_o are 0 and both accumulators are zero. A control word with value 0x0000, sent as the first word after reset, therefore leaves as 0x000F.
- R2: A valid data word (tx_ctrl_i=0) appears on tx_word_o unchanged one cycle after it is accepted. In that cycle tx_valid_o=1 and tx_ctrl_o=0.
- R3: A valid control word (tx_ctrl_i=1) appears one cycle later with tx_ctrl_o=1 and bits [15:4] unchanged. Its bits [3:0] are replaced by the computed parity.
- R4: The parity is computed as follows. A 16-bit accumulator A takes A = rotl1(A) XOR w for each valid data word w since the previous control word. For the control word c, the final value is F = rotl1(A) XOR (c with bits [3:0] set to 1111). The parity bit i is F[i]^F[i+4]^F[i+8]^F[i+12].
- R5: After every control word the accumulator returns to zero. A control word that directly follows another control word is coded from that word alone.
- R6: A cycle with the valid strobe low changes neither accumulator. On the egress side it produces tx_valid_o=0 in the next cycle.
- R7: rx_err_o is 1 for exactly the cycle after a valid control word whose bits [3:0] differ from the parity computed per R4 on the ingress stream. A matching control word gives 0.
- R8: Data words and invalid cycles never raise rx_err_o. The ingress accumulator clears after every control word, including one that caused an error.
- R9: When the egress output is fed straight into the ingress input, rx_err_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid_i | input | 1 | Egress word strobe |
| tx_ctrl_i | input | 1 | Egress word is a control word |
| tx_word_i | input | 16 | Egress word in |
| tx_valid_o | output | 1 | Egress word out strobe |
| tx_ctrl_o | output | 1 | Egress word out is a control word |
| tx_word_o | output | 16 | Egress word out, parity inserted in control words |
| rx_valid_i | input | 1 | Ingress word strobe |
| rx_ctrl_i | input | 1 | Ingress word is a control word |
| rx_word_i | input | 16 | Ingress word carrying the received parity in control words |
| rx_err_o | output | 1 | One-cycle parity mismatch pulse |

## Verification
When a control word arrives, it closes the current interval and also restarts the accumulator for the next one, all in the same cycle. Any word arriving in the following cycle must therefore be combined with zero and not with the old value. The bench provokes this with back-to-back control words, with a data word placed directly after a control word, and with a control word directly after reset. Each outgoing code and each error pulse is compared with a behavioural reference that restarts its own sum at every control word. Mismatching control words are sent in the middle of these sequences, so that an error on one interval can be seen not to spill into the next.

// File: rtl/dip_pkg.sv
package dip_pkg;
    localparam int WORD_W    = 16;
    localparam int PAR_W     = 4;
    localparam int FIELD_LSB = 0;
    localparam int NIBBLES   = WORD_W / PAR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PAR_W-1:0]  par_t;

    function automatic word_t rotl1(input word_t a);
        return {a[WORD_W-2:0], a[WORD_W-1]};
    endfunction

    // control word with its parity field forced to all ones
    function automatic word_t field_ones(input word_t w);
        word_t m;
        m = w;
        m[FIELD_LSB +: PAR_W] = '1;
        return m;
    endfunction

    function automatic par_t fold(input word_t a);
        par_t r;
        r = '0;
        for (int i = 0; i < NIBBLES; i++) begin
            r = r ^ a[i*PAR_W +: PAR_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/dip_accum.sv
module dip_accum
    import dip_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  valid_i,
    input  logic  ctrl_i,
    input  word_t word_i,
    output par_t  par_o
);
    typedef struct packed {
        word_t acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    // parity that closes the interval if the current word is a control word
    assign par_o = fold(rotl1(st_q.acc) ^ field_ones(word_i));

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            if (ctrl_i) begin
                st_d.acc = '0;
            end else begin
                st_d.acc = rotl1(st_q.acc) ^ word_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dip_gen.sv
module dip_gen
    import dip_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  valid_i,
    input  logic  ctrl_i,
    input  word_t word_i,
    output logic  valid_o,
    output logic  ctrl_o,
    output word_t word_o
);
    typedef struct packed {
        logic  valid;
        logic  ctrl;
        word_t word;
    } gen_state_t;

    gen_state_t st_d, st_q;
    par_t       par;

    dip_accum u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(valid_i),
        .ctrl_i (ctrl_i),
        .word_i (word_i),
        .par_o  (par)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.ctrl = ctrl_i;
            st_d.word = word_i;
            if (ctrl_i) begin
                st_d.word[FIELD_LSB +: PAR_W] = par;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign ctrl_o  = st_q.ctrl;
    assign word_o  = st_q.word;
endmodule

// File: rtl/dip_chk.sv
module dip_chk
    import dip_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  valid_i,
    input  logic  ctrl_i,
    input  word_t word_i,
    output logic  err_o
);
    typedef struct packed {
        logic err;
    } chk_state_t;

    chk_state_t st_d, st_q;
    par_t       par;

    dip_accum u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(valid_i),
        .ctrl_i (ctrl_i),
        .word_i (word_i),
        .par_o  (par)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = valid_i && ctrl_i && (word_i[FIELD_LSB +: PAR_W] != par);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;
endmodule

// File: rtl/diag_parity_unit.sv
module diag_parity_unit
    import dip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid_i,
    input  logic              tx_ctrl_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              tx_valid_o,
    output logic              tx_ctrl_o,
    output logic [WORD_W-1:0] tx_word_o,
    input  logic              rx_valid_i,
    input  logic              rx_ctrl_i,
    input  logic [WORD_W-1:0] rx_word_i,
    output logic              rx_err_o
);
    dip_gen u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(tx_valid_i),
        .ctrl_i (tx_ctrl_i),
        .word_i (tx_word_i),
        .valid_o(tx_valid_o),
        .ctrl_o (tx_ctrl_o),
        .word_o (tx_word_o)
    );

    dip_chk u_ingress (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(rx_valid_i),
        .ctrl_i (rx_ctrl_i),
        .word_i (rx_word_i),
        .err_o  (rx_err_o)
    );
endmodule

// File: rtl/dip_unit_chk.sv
module dip_unit_chk
    import dip_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid_i,
    input logic              tx_ctrl_i,
    input logic [WORD_W-1:0] tx_word_i,
    input logic              tx_valid_o,
    input logic              tx_ctrl_o,
    input logic [WORD_W-1:0] tx_word_o,
    input logic              rx_valid_i,
    input logic              rx_ctrl_i,
    input logic [WORD_W-1:0] rx_word_i,
    input logic              rx_err_o
);
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R2
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && tx_valid_o && !tx_ctrl_o |-> tx_word_o == $past(tx_word_i));

    // R3
    ctrl_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && tx_valid_o && tx_ctrl_o |->
            tx_word_o[WORD_W-1:PAR_W] == $past(tx_word_i[WORD_W-1:PAR_W]));

    // R6
    idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !$past(tx_valid_i) |-> !tx_valid_o);

    // R7
    err_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && rx_err_o |-> $past(rx_valid_i && rx_ctrl_i));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !$past(rx_valid_i) |-> !rx_err_o);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> !tx_valid_o && !rx_err_o);
endmodule

bind diag_parity_unit dip_unit_chk u_chk (.*);

// File: tb/diag_parity_unit_tb.sv
module diag_parity_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid_i = 1'b0, tx_ctrl_i = 1'b0;
    logic [15:0] tx_word_i = '0;
    logic        rx_valid_i = 1'b0, rx_ctrl_i = 1'b0;
    logic [15:0] rx_word_i = '0;
    logic        tx_valid_o, tx_ctrl_o, rx_err_o;
    logic [15:0] tx_word_o;

    int nchk = 0, nfail = 0;
    logic [15:0] m_tx = '0, m_rx = '0;

    always #4 clk = ~clk;

    diag_parity_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid_i(tx_valid_i), .tx_ctrl_i(tx_ctrl_i), .tx_word_i(tx_word_i),
        .tx_valid_o(tx_valid_o), .tx_ctrl_o(tx_ctrl_o), .tx_word_o(tx_word_o),
        .rx_valid_i(rx_valid_i), .rx_ctrl_i(rx_ctrl_i), .rx_word_i(rx_word_i),
        .rx_err_o(rx_err_o)
    );

    // behavioural parity of a closing control word
    function automatic logic [3:0] ref_par(input logic [15:0] acc, input logic [15:0] c);
        logic [31:0] t;
        logic [15:0] f;
        logic [3:0]  p;
        t = {16'h0, acc} * 2;
        f = t[15:0] + {15'h0, t[16]};
        f = f ^ (c | 16'h000F);
        p = 4'h0;
        for (int k = 0; k < 16; k++) p[k % 4] = p[k % 4] ^ f[k];
        return p;
    endfunction

    function automatic logic [15:0] ref_acc(input logic [15:0] acc, input logic [15:0] w);
        return {acc[14:0], acc[15]} ^ w;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; applies one cycle and compares at the next falling edge
    task automatic step(input logic tv, input logic tc, input logic [15:0] tw,
                        input logic rv, input logic rc, input logic [15:0] rw,
                        input string tag);
        logic [15:0] exp_w;
        logic        exp_e;
        exp_w = tw;
        if (tv && tc) exp_w[3:0] = ref_par(m_tx, tw);
        exp_e = rv && rc && (rw[3:0] != ref_par(m_rx, rw));
        tx_valid_i = tv; tx_ctrl_i = tc; tx_word_i = tw;
        rx_valid_i = rv; rx_ctrl_i = rc; rx_word_i = rw;
        @(posedge clk);
        @(negedge clk);
        check(tx_valid_o == tv, {tag, " tx_valid"}, 32'(tx_valid_o), 32'(tv));
        if (tv) begin
            check(tx_ctrl_o == tc, {tag, " tx_ctrl"}, 32'(tx_ctrl_o), 32'(tc));
            check(tx_word_o == exp_w, {tag, " tx_word"}, 32'(tx_word_o), 32'(exp_w));
        end
        check(rx_err_o == exp_e, {tag, " rx_err"}, 32'(rx_err_o), 32'(exp_e));
        if (tv) m_tx = tc ? 16'h0 : ref_acc(m_tx, tw);
        if (rv) m_rx = rc ? 16'h0 : ref_acc(m_rx, rw);
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        nchk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [3:0]  p;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tx_valid_o == 1'b0, "R1 tx_valid in reset", 32'(tx_valid_o), 0);
        check(rx_err_o == 1'b0, "R1 rx_err in reset", 32'(rx_err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R5: zero accumulator, lone control word 0x0000 -> 0x000F
        step(1, 1, 16'h0000, 1, 1, 16'h000F, "R1 first ctrl");
        check(tx_word_o == 16'h000F, "R1 literal code", 32'(tx_word_o), 32'h000F);
        // R4 literal: data 0x0001 then ctrl 0x0000 -> 0x000D
        step(1, 0, 16'h0001, 1, 0, 16'h0001, "R4 data");
        step(1, 1, 16'h0000, 1, 1, 16'h000D, "R4 ctrl");
        check(tx_word_o == 16'h000D, "R4 literal code", 32'(tx_word_o), 32'h000D);
        // R5 back-to-back control words
        step(1, 1, 16'hA5A0, 1, 1, 16'hA5A0 | 16'(ref_par(16'h0, 16'hA5A0)), "R5 ctrl a");
        step(1, 1, 16'h3C30, 1, 1, 16'h3C30 | 16'(ref_par(16'h0, 16'h3C30)), "R5 ctrl b");
        // R6 invalid cycles with garbage ignored
        step(1, 0, 16'h1234, 1, 0, 16'h1234, "R2 data");
        step(0, 1, 16'hFFFF, 0, 1, 16'hFFF0, "R6 idle ctrl");
        step(0, 0, 16'hBEEF, 0, 0, 16'hBEEF, "R6 idle data");
        step(1, 1, 16'h8000, 1, 1, 16'h8000 | 16'(ref_par(m_rx, 16'h8000)), "R6 ctrl after gap");
        // R7: wrong field, then R8: next interval clean
        step(1, 0, 16'h00FF, 1, 0, 16'h00FF, "R8 data");
        p = ref_par(m_rx, 16'h4000) ^ 4'h1;
        step(1, 1, 16'h4000, 1, 1, 16'h4000 | 16'(p), "R7 bad ctrl");
        check(rx_err_o == 1'b1, "R7 pulse", 32'(rx_err_o), 1);
        step(1, 0, 16'h0F0F, 1, 0, 16'h0F0F, "R8 data after err");
        check(rx_err_o == 1'b0, "R7 one cycle", 32'(rx_err_o), 0);
        step(1, 1, 16'h7770, 1, 1, 16'h7770 | 16'(ref_par(m_rx, 16'h7770)), "R8 clean ctrl");
        // random mixed traffic (R2 R3 R4 R6 R7 R8)
        for (int i = 0; i < 400; i++) begin
            logic v, c, bad;
            v = ($urandom % 5) != 0;
            c = ($urandom % 4) == 0;
            bad = ($urandom % 3) == 0;
            w = 16'($urandom);
            p = ref_par(m_rx, w) ^ (bad ? 4'(1 + $urandom % 15) : 4'h0);
            step(v, c, w, v, c, c ? {w[15:4], p} : w, "R4 mixed");
        end
        // R9 loopback: feed egress output into ingress input
        step(0, 0, 16'h0, 0, 0, 16'h0, "R9 align");
        for (int i = 0; i < 300; i++) begin
            logic v, c;
            v = ($urandom % 6) != 0;
            c = ($urandom % 3) == 0;
            w = 16'($urandom);
            step(v, c, w, tx_valid_o, tx_ctrl_o, tx_word_o, "R9 loopback");
            check(rx_err_o == 1'b0, "R9 no error", 32'(rx_err_o), 0);
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule